// File: doc/BRIEF.md
# Received Word Byte-Parity Checker with Header Error Hold

This block sits on the receive side of a 32-bit parallel channel. Every word comes with four parity bits, one for each byte. The block forwards each word and its parity bits to the host one clock later, exactly as received. Words with bad parity are never dropped, corrected or masked. Alongside the forwarded word, it raises an error flag when any byte fails its parity check.

While the sender is asking for a connection, the word lines carry a header field that the host inspects before it decides. During this phase the check runs on every clock. A failing header keeps the flag high until one of these events occurs:

- the header settles to correct parity;
- the host accepts or rejects the request;
- the sender lowers its request line.

After the host has decided, header errors are no longer reported for the rest of that request. Outside a request, the flag describes only the word it belongs to.

Top module: `rxw_parity_guard`

## Requirements
- R1: `dout_data` and `dout_par` equal the `rx_data` and `rx_par` sampled on the previous clock edge. This holds for words with bad parity too.
- R2: Parity bit k covers data bits 8k+7 down to 8k and uses odd parity. A byte is in error when the count of ones in its eight data bits plus its parity bit is even. A word is in error when any of its bytes is in error.
- R3: `par_err` is registered one clock behind the word on `dout_data`, so it appears two clocks after the word entered on `rx_data`.
- R4: When `conn_req` is low, `par_err` reflects only the parity of its own word and holds nothing from earlier words.
- R5: When `conn_req` is high, `src_request` is high and the host has not decided, `par_err` is high for every header word that is in error. It goes low as soon as a header word has correct parity.
- R6: A header word sampled with `host_accept` or `host_reject` high produces `par_err` low. Every later header word of the same request also produces `par_err` low, until `conn_req` has been low for at least one word.
- R7: A header word sampled with `src_request` low produces `par_err` low, whatever its parity.
- R8: While `rst_n` is low, `dout_data`, `dout_par` and `par_err` are zero. The first two words after reset is released produce no error from the reset contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 32 | Received word |
| rx_par | input | 4 | Received byte parity bits (odd) |
| conn_req | input | 1 | High while a connection request is pending; the word is then a header |
| src_request | input | 1 | Sender's request line |
| host_accept | input | 1 | Host accepts the pending request |
| host_reject | input | 1 | Host rejects the pending request |
| dout_data | output | 32 | Forwarded word, one clock late |
| dout_par | output | 4 | Forwarded parity bits, one clock late |
| par_err | output | 1 | Parity error flag, one clock behind `dout_data` |

## Verification
The hardest state to reach is a request in which the host has already decided but the header still has bad parity. In that state the flag must stay low, and it must recover only after `conn_req` has dropped and a new request has begun. The stimulus first holds a bad header for several clocks, then pulses accept or reject for one word while the bad header stays on the lines. It then drops and re-raises `conn_req` with the same bad header. A further directed pass lowers `src_request` under a bad header. A long random pass then mixes request episodes, host decisions and single-byte parity faults, and a behavioural model compares its results with the outputs on every clock.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  // Sideband that travels with a word through the capture stage.
  typedef struct packed {
    logic valid;
    logic hdr;
    logic src;
    logic acc;
    logic rej;
  } bpc_ctl_t;

  localparam bpc_ctl_t BPC_CTL_IDLE = '{valid: 1'b0, hdr: 1'b0, src: 1'b0, acc: 1'b0, rej: 1'b0};

endpackage

// File: rtl/bpc_byte_par.sv
module bpc_byte_par #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [BYTES*BYTE_W-1:0] data,
  input  logic [BYTES-1:0]        par,
  output logic [BYTES-1:0]        byte_bad,
  output logic                    any_bad
);

  // Odd parity: the data bits and the parity bit together hold an odd number of ones.
  function automatic logic lane_fails(input logic [BYTE_W-1:0] lane, input logic pbit);
    return ~(^{pbit, lane});
  endfunction

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign byte_bad[k] = lane_fails(data[k*BYTE_W +: BYTE_W], par[k]);
  end

  assign any_bad = |byte_bad;

endmodule

// File: rtl/bpc_stage.sv
module bpc_stage
  import bpc_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTES*BYTE_W-1:0] in_data,
  input  logic [BYTES-1:0]        in_par,
  input  logic                    in_hdr,
  input  logic                    in_src,
  input  logic                    in_acc,
  input  logic                    in_rej,
  output logic [BYTES*BYTE_W-1:0] q_data,
  output logic [BYTES-1:0]        q_par,
  output bpc_ctl_t                q_ctl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_par  <= '0;
      q_ctl  <= BPC_CTL_IDLE;
    end else begin
      q_data <= in_data;
      q_par  <= in_par;
      q_ctl  <= '{valid: 1'b1, hdr: in_hdr, src: in_src, acc: in_acc, rej: in_rej};
    end
  end

endmodule

// File: rtl/bpc_hdr_hold.sv
module bpc_hdr_hold
  import bpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bpc_ctl_t ctl,
  input  logic     word_bad,
  output logic     err_q,
  output logic     decided_q,
  output logic     release_evt,
  output logic     hdr_flag,
  output logic     data_flag
);

  logic err_d;
  logic decided_d;

  always_comb begin
    release_evt = ctl.hdr & (~ctl.src | ctl.acc | ctl.rej | decided_q);
    hdr_flag    = ctl.valid & ctl.hdr & ~release_evt & word_bad;
    data_flag   = ctl.valid & ~ctl.hdr & word_bad;
    err_d       = hdr_flag | data_flag;
    decided_d   = (ctl.valid & ctl.hdr) ? (decided_q | ctl.acc | ctl.rej) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      decided_q <= 1'b0;
    end else begin
      err_q     <= err_d;
      decided_q <= decided_d;
    end
  end

endmodule

// File: rtl/rxw_parity_guard.sv
module rxw_parity_guard
  import bpc_pkg::*;
#(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BYTES*BYTE_W-1:0] rx_data,
  input  logic [BYTES-1:0]        rx_par,
  input  logic                    conn_req,
  input  logic                    src_request,
  input  logic                    host_accept,
  input  logic                    host_reject,
  output logic [BYTES*BYTE_W-1:0] dout_data,
  output logic [BYTES-1:0]        dout_par,
  output logic                    par_err
);

  localparam int DW = BYTES * BYTE_W;

  logic [DW-1:0]    s1_data;
  logic [BYTES-1:0] s1_par;
  bpc_ctl_t         s1_ctl;
  logic [BYTES-1:0] s1_byte_bad;
  logic             s1_bad;
  logic             hdr_decided;
  logic             hdr_release;
  logic             hdr_flag;
  logic             data_flag;

  // Named copies of the stage-1 sideband for the checker
  logic s1_valid, s1_hdr, s1_src, s1_acc, s1_rej;
  assign s1_valid = s1_ctl.valid;
  assign s1_hdr   = s1_ctl.hdr;
  assign s1_src   = s1_ctl.src;
  assign s1_acc   = s1_ctl.acc;
  assign s1_rej   = s1_ctl.rej;

  bpc_stage #(.BYTES(BYTES), .BYTE_W(BYTE_W)) stage_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_data (rx_data),
    .in_par  (rx_par),
    .in_hdr  (conn_req),
    .in_src  (src_request),
    .in_acc  (host_accept),
    .in_rej  (host_reject),
    .q_data  (s1_data),
    .q_par   (s1_par),
    .q_ctl   (s1_ctl)
  );

  bpc_byte_par #(.BYTES(BYTES), .BYTE_W(BYTE_W)) check_i (
    .data     (s1_data),
    .par      (s1_par),
    .byte_bad (s1_byte_bad),
    .any_bad  (s1_bad)
  );

  bpc_hdr_hold hold_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (s1_ctl),
    .word_bad    (s1_bad),
    .err_q       (par_err),
    .decided_q   (hdr_decided),
    .release_evt (hdr_release),
    .hdr_flag    (hdr_flag),
    .data_flag   (data_flag)
  );

  assign dout_data = s1_data;
  assign dout_par  = s1_par;

endmodule

// File: rtl/bpc_guard_chk.sv
module bpc_guard_chk #(
  parameter int DW = 32,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] rx_data,
  input logic [PW-1:0] rx_par,
  input logic [DW-1:0] dout_data,
  input logic [PW-1:0] dout_par,
  input logic          par_err,
  input logic          s1_valid,
  input logic          s1_hdr,
  input logic          s1_src,
  input logic          s1_acc,
  input logic          s1_rej,
  input logic          s1_bad,
  input logic          hdr_decided
);

  logic warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;
  end

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (dout_data == $past(rx_data) && dout_par == $past(rx_par)));

  // R4
  plain_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_hdr) |=> (par_err == $past(s1_bad)));

  // R5
  hdr_bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_hdr && s1_src && !s1_acc && !s1_rej && !hdr_decided && s1_bad) |=> par_err);

  // R6
  host_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_hdr && (s1_acc || s1_rej)) |=> !par_err);

  // R7
  src_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_hdr && !s1_src) |=> !par_err);

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !par_err);

endmodule

bind rxw_parity_guard bpc_guard_chk #(.DW(BYTES*BYTE_W), .PW(BYTES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_data     (rx_data),
  .rx_par      (rx_par),
  .dout_data   (dout_data),
  .dout_par    (dout_par),
  .par_err     (par_err),
  .s1_valid    (s1_valid),
  .s1_hdr      (s1_hdr),
  .s1_src      (s1_src),
  .s1_acc      (s1_acc),
  .s1_rej      (s1_rej),
  .s1_bad      (s1_bad),
  .hdr_decided (hdr_decided)
);

// File: tb/rxw_parity_guard_tb_top.sv
`timescale 1ns/1ps
module rxw_parity_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rx_data = '0;
  logic [3:0]  rx_par = '0;
  logic        conn_req = 1'b0, src_request = 1'b0, host_accept = 1'b0, host_reject = 1'b0;
  logic [31:0] dout_data;
  logic [3:0]  dout_par;
  logic        par_err;

  always #2 clk = ~clk;

  rxw_parity_guard dut_i (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_par(rx_par),
    .conn_req(conn_req), .src_request(src_request),
    .host_accept(host_accept), .host_reject(host_reject),
    .dout_data(dout_data), .dout_par(dout_par), .par_err(par_err)
  );

  typedef struct {
    logic [31:0] d;
    logic [3:0]  p;
    bit hdr, src, acc, rej, valid;
  } rec_t;

  rec_t hist[$];
  bit   decided = 0;
  int   checks = 0;
  int   fails = 0;
  bit   done = 0;
  string cur_req = "R1";

  // Parity bits that make every byte odd (R2): set when the byte's own count of ones is even.
  function automatic logic [3:0] odd_par(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ($countones(d[k*8 +: 8]) % 2 == 0);
    return p;
  endfunction

  function automatic bit word_bad(input rec_t r);
    int bad = 0;
    for (int k = 0; k < 4; k++)
      if ((($countones(r.d[k*8 +: 8]) + int'(r.p[k])) % 2) == 0) bad = 1;
    return bad != 0;
  endfunction

  // Behavioural reference for the flag produced from record r (R3..R7)
  function automatic bit model_err(input rec_t r);
    bit e;
    if (!r.valid) begin
      decided = 0;
      return 0;
    end
    if (r.hdr) begin
      e = r.src && !r.acc && !r.rej && !decided && word_bad(r);
      if (r.acc || r.rej) decided = 1;
    end else begin
      e = word_bad(r);
      decided = 0;
    end
    return e;
  endfunction

  task automatic check1(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [3:0] p, input bit hdr, input bit src, input bit acc, input bit rej);
    rec_t r;
    bit   e;
    r.d = d; r.p = p; r.hdr = hdr; r.src = src; r.acc = acc; r.rej = rej; r.valid = 1;
    rx_data = d; rx_par = p; conn_req = hdr; src_request = src; host_accept = acc; host_reject = rej;
    hist.push_back(r);
    @(negedge clk);
    check1("R1", "dout_data", dout_data, hist[$].d);
    check1("R1", "dout_par", {28'd0, dout_par}, {28'd0, hist[$].p});
    e = model_err(hist[$-1]);
    check1(cur_req, "par_err", {31'd0, par_err}, {31'd0, e});
    if (hist.size() > 4) void'(hist.pop_front());
  endtask

  // A word with correct parity, then one with a single byte flipped
  function automatic logic [3:0] bad_par(input logic [31:0] d, input int lane);
    logic [3:0] p = odd_par(d);
    p[lane] = ~p[lane];
    return p;
  endfunction

  initial begin
    rec_t z;
    logic [31:0] hw;
    z.d = '0; z.p = '0; z.hdr = 0; z.src = 0; z.acc = 0; z.rej = 0; z.valid = 0;
    repeat (3) @(negedge clk);
    // R8: quiet outputs under reset
    check1("R8", "dout_data in reset", dout_data, 32'd0);
    check1("R8", "dout_par in reset", {28'd0, dout_par}, 32'd0);
    check1("R8", "par_err in reset", {31'd0, par_err}, 32'd0);
    rst_n = 1'b1;
    hist.push_back(z);

    // R8/R1/R2: plain words, good and bad in each lane
    cur_req = "R8";
    apply(32'h1234_5678, odd_par(32'h1234_5678), 0, 1, 0, 0);
    cur_req = "R2";
    for (int lane = 0; lane < 4; lane++) begin
      apply(32'hA5A5_0F0F ^ lane, bad_par(32'hA5A5_0F0F ^ lane, lane), 0, 1, 0, 0);
      apply(32'hFFFF_0000 + lane, odd_par(32'hFFFF_0000 + lane), 0, 1, 0, 0);
    end
    apply(32'h0, 4'h0, 0, 1, 0, 0);            // all lanes bad
    // R4: no holding between plain words
    cur_req = "R4";
    apply(32'hDEAD_BEEF, bad_par(32'hDEAD_BEEF, 3), 0, 1, 0, 0);
    apply(32'hDEAD_BEEF, odd_par(32'hDEAD_BEEF), 0, 1, 0, 0);
    apply(32'hCAFE_F00D, odd_par(32'hCAFE_F00D), 0, 1, 0, 0);

    // R5: bad header held, released by good parity
    cur_req = "R5";
    hw = 32'h0BAD_0001;
    repeat (4) apply(hw, bad_par(hw, 1), 1, 1, 0, 0);
    repeat (2) apply(hw, odd_par(hw), 1, 1, 0, 0);
    apply(hw, bad_par(hw, 2), 1, 1, 0, 0);
    apply(hw, odd_par(hw), 0, 1, 0, 0);

    // R6: accept while bad, stays low, recovers after a new request
    cur_req = "R6";
    repeat (3) apply(hw, bad_par(hw, 0), 1, 1, 0, 0);
    apply(hw, bad_par(hw, 0), 1, 1, 1, 0);
    repeat (3) apply(hw, bad_par(hw, 0), 1, 1, 0, 0);
    apply(hw, bad_par(hw, 0), 0, 1, 0, 0);
    repeat (2) apply(hw, bad_par(hw, 0), 1, 1, 0, 0);
    apply(hw, bad_par(hw, 3), 1, 1, 0, 1);     // reject
    repeat (2) apply(hw, bad_par(hw, 3), 1, 1, 0, 0);
    apply(hw, odd_par(hw), 0, 0, 0, 0);

    // R7: sender drops request under bad header
    cur_req = "R7";
    repeat (2) apply(hw, bad_par(hw, 2), 1, 1, 0, 0);
    repeat (2) apply(hw, bad_par(hw, 2), 1, 0, 0, 0);
    apply(hw, bad_par(hw, 2), 1, 1, 0, 0);
    apply(hw, odd_par(hw), 0, 1, 0, 0);

    // R3: random mix, every clock compared against the model
    cur_req = "R3";
    begin
      bit hdr = 0;
      for (int i = 0; i < 2000; i++) begin
        logic [31:0] d = $urandom;
        logic [3:0]  p = odd_par(d);
        if ($urandom_range(0, 9) == 0) hdr = ~hdr;
        if ($urandom_range(0, 2) == 0) p[$urandom_range(0, 3)] ^= 1'b1;
        apply(d, p, hdr, $urandom_range(0, 9) != 0,
              $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule